// File: doc/BRIEF.md
# Conditional Skip Test Unit

This block executes the skip-test class of operate instructions in a small 12-bit processor. When the execute strobe is high, it decodes the instruction word. If the word belongs to the skip-test class, the block checks the accumulator sign, the accumulator-is-zero status and the link bit against the conditions that the word selects. It then reports whether the program counter should step over the next instruction. After the test it can clear the accumulator. It can also merge the front-panel switch value into the accumulator and request a halt.

Merging the switches and halting are privileged. When the user-mode flag is set, either request raises a trap instead of acting, while the skip and the clear still take effect. Results are registered. The new accumulator appears one clock after the strobe and holds until the next strobe. The skip, halt and trap outputs are single-cycle pulses in that same cycle. The program counter and the trap handler live outside this block.

Instruction bits are written below as Verilog indices of `instr[11:0]`, where `instr[11]` is the most significant bit.

Top module: `skip_test_unit`

## Requirements
- R1: A word is in the skip-test class only when `instr[11:8]` is 4'hF and `instr[0]` is 0. Any other word under the strobe produces no skip, no halt and no trap, and leaves the accumulator unchanged.
- R2: With the sense bit `instr[3]` at 0, the block skips if any selected condition holds. The selectors are: `instr[6]` for accumulator negative (bit 11 set), `instr[5]` for accumulator zero, and `instr[4]` for link set.
- R3: With `instr[3]` at 1, the same selector bits test the inverse conditions: accumulator non-negative, accumulator nonzero and link clear. The block skips only when every selected inverse condition holds.
- R4: With no selector bit set, the block always skips when `instr[3]` is 1 and never skips when `instr[3]` is 0.
- R5: All tests use the incoming accumulator, so a clear in the same word does not change the outcome of the test.
- R6: Bit `instr[7]` clears the accumulator after the test.
- R7: Outside user mode, bit `instr[2]` ORs the switch value into the accumulator after any clear. Clear together with this bit loads the switches.
- R8: Outside user mode, bit `instr[1]` produces a halt pulse.
- R9: In user mode, `instr[2]` or `instr[1]` produces a trap pulse. The switch merge and the halt are then suppressed, while the skip and the clear still take effect.
- R10: Results appear on the clock edge after the strobe. Skip, halt and trap are high for that single cycle only. Without the strobe the accumulator output holds and the pulses stay low.
- R11: During synchronous active-low reset, the accumulator output and all pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec | input | 1 | Execute strobe for the current word |
| instr | input | 12 | Instruction word |
| ac_in | input | DATA_W | Incoming accumulator |
| link_in | input | 1 | Incoming link bit |
| switches | input | DATA_W | Front-panel switch value |
| user_mode | input | 1 | High when running unprivileged code |
| ac_out | output | DATA_W | Updated accumulator |
| skip | output | 1 | Pulse: step the program counter over the next word |
| halt | output | 1 | Pulse: stop after this instruction |
| trap | output | 1 | Pulse: privileged request from user mode |

## Verification
The bench targets a clear combined with a zero test. A design that clears before testing would skip on a nonzero accumulator. It also issues an empty selection in both sense settings. A design that reduces an empty set the wrong way would skip when it should not, or fail to skip when it should. User-mode words that combine a privileged bit with a skip and a clear show whether a design drops the skip or the clear on a trap, or lets the switch value leak into the accumulator. Words from other instruction classes, including one that differs only in the lowest bit, show whether the class decode is too loose.

// File: rtl/skip_test_pkg.sv
// Package: shared field positions and the decoded-operation type for the
// skip-test unit. Assumes a 12-bit instruction word, MSB at index 11.
package skip_test_pkg;
    localparam int INSTR_W   = 12;
    localparam int NUM_COND  = 3;
    localparam int B_SENSE   = 3;
    localparam int B_CLEAR   = 7;
    localparam int B_NEG     = 6;
    localparam int B_ZERO    = 5;
    localparam int B_LINK    = 4;
    localparam int B_SWOR    = 2;
    localparam int B_HALT    = 1;

    // Decoded fields of a skip-test word.
    typedef struct packed {
        logic                is_grp2;
        logic                and_sense;
        logic                clear;
        logic [NUM_COND-1:0] cond_sel;   // [0] negative, [1] zero, [2] link
        logic                sw_or;
        logic                halt_req;
    } op2_t;
endpackage

// File: rtl/skip_decode.sv
// Module: skip_decode
// Splits an instruction word into skip-test fields. Purely combinational.
// Assumes the field positions held in skip_test_pkg.
module skip_decode
    import skip_test_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output op2_t               op
);
    // Recognise the class and pick out every field.
    always_comb begin
        op.is_grp2   = (instr[INSTR_W-1:INSTR_W-4] == 4'hF) && !instr[0];
        op.and_sense = instr[B_SENSE];
        op.clear     = instr[B_CLEAR];
        op.cond_sel  = {instr[B_LINK], instr[B_ZERO], instr[B_NEG]};
        op.sw_or     = instr[B_SWOR];
        op.halt_req  = instr[B_HALT];
    end
endmodule

// File: rtl/skip_cond_eval.sv
// Module: skip_cond_eval
// Evaluates the skip decision from the selected conditions. With sense low,
// it ORs the selected conditions. With sense high, it ANDs their inverses.
// Assumes the conditions are sampled from the incoming accumulator.
module skip_cond_eval #(
    parameter int NC = 3
) (
    input  logic [NC-1:0] cond,
    input  logic [NC-1:0] sel,
    input  logic          and_sense,
    output logic          skip_now
);
    logic [NC-1:0] hit_or;
    logic [NC-1:0] pass_and;

    // One slice per condition: an OR hit and an AND pass.
    for (genvar i = 0; i < NC; i++) begin : g_cond
        assign hit_or[i]   = sel[i] & cond[i];
        assign pass_and[i] = ~sel[i] | ~cond[i];
    end

    // Reduce: an empty AND set passes, an empty OR set never hits.
    always_comb skip_now = and_sense ? (&pass_and) : (|hit_or);
endmodule

// File: rtl/skip_ac_update.sv
// Module: skip_ac_update
// Computes the next accumulator: optional clear, then optional switch OR.
// Assumes the caller has already removed the switch OR if a trap is raised.
module skip_ac_update #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] ac_in,
    input  logic [DATA_W-1:0] switches,
    input  logic              clear,
    input  logic              sw_en,
    output logic [DATA_W-1:0] ac_next
);
    // Clear first, then merge the switches.
    always_comb begin
        ac_next = clear ? '0 : ac_in;
        if (sw_en) ac_next = ac_next | switches;
    end
endmodule

// File: rtl/skip_test_unit.sv
// Module: skip_test_unit
// Executes one skip-test word per execute strobe. Registers the new
// accumulator and pulses skip, halt and trap one cycle later.
// Assumes synchronous active-low reset and exec held for one cycle per word.
module skip_test_unit
    import skip_test_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [11:0]       instr,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              link_in,
    input  logic [DATA_W-1:0] switches,
    input  logic              user_mode,
    output logic [DATA_W-1:0] ac_out,
    output logic              skip,
    output logic              halt,
    output logic              trap
);
    localparam int SIGN_B = DATA_W - 1;

    op2_t                op;
    logic [NUM_COND-1:0] cond;
    logic                skip_now;
    logic                trap_now;
    logic [DATA_W-1:0]   ac_next;

    skip_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    // Gather the raw conditions from the incoming accumulator and link.
    always_comb cond = {link_in, (ac_in == '0), ac_in[SIGN_B]};

    skip_cond_eval #(.NC(NUM_COND)) u_eval (
        .cond      (cond),
        .sel       (op.cond_sel),
        .and_sense (op.and_sense),
        .skip_now  (skip_now)
    );

    // A privileged request from user mode becomes a trap.
    always_comb trap_now = op.is_grp2 && user_mode && (op.sw_or || op.halt_req);

    skip_ac_update #(.DATA_W(DATA_W)) u_ac (
        .ac_in    (ac_in),
        .switches (switches),
        .clear    (op.clear),
        .sw_en    (op.sw_or && !trap_now),
        .ac_next  (ac_next)
    );

    // Register the results; the pulses last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_out <= '0;
            skip   <= 1'b0;
            halt   <= 1'b0;
            trap   <= 1'b0;
        end else begin
            skip <= exec && op.is_grp2 && skip_now;
            halt <= exec && op.is_grp2 && op.halt_req && !trap_now;
            trap <= exec && trap_now;
            if (exec && op.is_grp2) ac_out <= ac_next;
            else if (exec)          ac_out <= ac_in;
        end
    end

    assert_foreign_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !((instr[11:8] == 4'hF) && !instr[0])) |=>
            (ac_out == $past(ac_in) && !skip && !halt && !trap));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && instr[11:8] == 4'hF && !instr[0] && instr[7] && !instr[2]) |=>
            (ac_out == '0));

    assert_trap_needs_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !user_mode) |=> !trap);

    assert_trap_blocks_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !halt);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> (!skip && !halt && !trap));

    assert_ac_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(ac_out));
endmodule

// File: tb/skip_test_unit_test.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module skip_test_unit_test;
    localparam int DW = 12;
    localparam logic [11:0] G2 = 12'hF00, SNS = 12'h008, CLR = 12'h080,
        NEG = 12'h040, ZER = 12'h020, LNK = 12'h010, SWO = 12'h004, HLT = 12'h002;

    typedef struct {
        logic [DW-1:0] ac;
        logic skip, halt, trap;
        string req;
    } exp_t;

    logic clk = 0, rst_n = 0, exec = 0, link_in = 0, user_mode = 0;
    logic [11:0] instr = '0;
    logic [DW-1:0] ac_in = '0, switches = '0;
    logic [DW-1:0] ac_out;
    logic skip, halt, trap;
    int checks = 0, fails = 0;
    logic [DW-1:0] last_ac = '0;
    bit done = 0;
    exp_t q[$];

    skip_test_unit #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .exec(exec), .instr(instr), .ac_in(ac_in),
        .link_in(link_in), .switches(switches), .user_mode(user_mode),
        .ac_out(ac_out), .skip(skip), .halt(halt), .trap(trap));

    always #5 clk = ~clk;

    // Reference model written from the requirements.
    function automatic exp_t model(logic [11:0] w, logic [DW-1:0] a, logic l,
                                   logic [DW-1:0] sw, logic u, string r);
        exp_t e;
        logic grp, neg, zer, tr;
        grp = (w[11:8] == 4'hF) && !w[0];
        neg = a[DW-1];
        zer = (a == 0);
        e.req = r;
        if (!grp) begin
            e.ac = a; e.skip = 0; e.halt = 0; e.trap = 0;
            return e;
        end
        if (w[3]) e.skip = (!w[6] || !neg) && (!w[5] || !zer) && (!w[4] || !l);
        else      e.skip = (w[6] && neg) || (w[5] && zer) || (w[4] && l);
        tr = u && (w[2] || w[1]);
        e.trap = tr;
        e.halt = w[1] && !tr;
        e.ac = w[7] ? '0 : a;
        if (w[2] && !tr) e.ac = e.ac | sw;
        return e;
    endfunction

    task automatic check(string r, logic [31:0] act, logic [31:0] expv, string what);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
        end
    endtask

    // Driver: one strobed word followed by one idle cycle.
    task automatic run(logic [11:0] w, logic [DW-1:0] a, logic l,
                       logic [DW-1:0] sw, logic u, string r);
        @(negedge clk);
        instr = w; ac_in = a; link_in = l; switches = sw; user_mode = u; exec = 1;
        q.push_back(model(w, a, l, sw, u, r));
        @(negedge clk);
        exec = 0;
        ac_in = ~a;
        @(negedge clk);
    endtask

    // Monitor: compare after each strobe edge, check quiet idle cycles.
    always @(posedge clk) begin
        if (rst_n && !done) begin
            if (exec) begin
                exp_t e;
                #2;
                if (q.size() == 0) begin
                    check("R10", 1, 0, "result without pending item");
                end else begin
                    e = q.pop_front();
                    check(e.req, ac_out, e.ac, "ac_out");
                    check(e.req, skip, e.skip, "skip");
                    check(e.req, halt, e.halt, "halt");
                    check(e.req, trap, e.trap, "trap");
                    last_ac = e.ac;
                end
            end else if (q.size() == 0) begin
                #2;
                check("R10", {skip, halt, trap}, 0, "idle pulses");
                check("R10", ac_out, last_ac, "idle ac hold");
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        exec = 1; ac_in = 12'hABC; instr = G2 | HLT | SWO; switches = 12'hFFF;
        repeat (3) @(negedge clk);
        check("R11", {ac_out, skip, halt, trap}, 0, "reset state");
        exec = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: words outside the class
        run(12'hF01, 12'h123, 1, 12'hFFF, 0, "R1");
        run(12'hE80 | HLT, 12'h456, 0, 12'hFFF, 0, "R1");
        run(12'h7FE, 12'h000, 1, 12'hFFF, 1, "R1");
        // R2: OR sense
        run(G2 | NEG, 12'h800, 0, 0, 0, "R2");
        run(G2 | NEG, 12'h7FF, 0, 0, 0, "R2");
        run(G2 | ZER, 12'h000, 0, 0, 0, "R2");
        run(G2 | LNK, 12'h001, 1, 0, 0, "R2");
        run(G2 | NEG | ZER, 12'h000, 0, 0, 0, "R2");
        run(G2 | NEG | ZER | LNK, 12'h001, 0, 0, 0, "R2");
        // R3: AND sense
        run(G2 | SNS | NEG | ZER, 12'h001, 0, 0, 0, "R3");
        run(G2 | SNS | NEG | ZER, 12'h000, 0, 0, 0, "R3");
        run(G2 | SNS | NEG | ZER | LNK, 12'h7FF, 1, 0, 0, "R3");
        run(G2 | SNS | LNK, 12'h800, 0, 0, 0, "R3");
        run(G2 | SNS | NEG, 12'h800, 0, 0, 0, "R3");
        // R4: empty selection
        run(G2 | SNS, 12'h000, 1, 0, 0, "R4");
        run(G2, 12'h800, 1, 0, 0, "R4");
        // R5 and R6: the test uses the incoming accumulator, then clears
        run(G2 | CLR | ZER, 12'h005, 0, 0, 0, "R5");
        run(G2 | SNS | CLR | ZER, 12'h005, 0, 0, 0, "R5");
        run(G2 | CLR, 12'hFFF, 0, 12'h0F0, 0, "R6");
        // R7: switch OR
        run(G2 | SWO, 12'h00F, 0, 12'hA30, 0, "R7");
        run(G2 | SWO | CLR, 12'hFFF, 0, 12'h5A5, 0, "R7");
        // R8: halt
        run(G2 | HLT, 12'h321, 0, 0, 0, "R8");
        // R9: user-mode trap
        run(G2 | SWO, 12'h00F, 0, 12'hA30, 1, "R9");
        run(G2 | HLT | CLR | ZER, 12'h000, 0, 0, 1, "R9");
        run(G2 | SNS | SWO | HLT | CLR, 12'h444, 0, 12'hFFF, 1, "R9");
        run(G2 | CLR | NEG, 12'h800, 0, 0, 1, "R9");
        // R10: back-to-back strobes
        @(negedge clk);
        instr = G2 | ZER; ac_in = 0; exec = 1;
        q.push_back(model(G2 | ZER, 0, 0, 0, 0, "R10"));
        @(negedge clk);
        instr = G2 | LNK; ac_in = 12'h00A; link_in = 0;
        q.push_back(model(G2 | LNK, 12'h00A, 0, 0, 0, "R10"));
        @(negedge clk);
        exec = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule